// File: doc/BRIEF.md
# Register File with Indirect Pointer Pairs

This block holds the working registers of a single-cycle RISC datapath: 32 registers of 8 bits. Two byte read ports and one write port serve the datapath. Both reads are combinational, and a write lands at the clock edge. The write port stores either one byte or a 16-bit word. A word goes into an even-aligned register pair, with the low byte in the even register. A 16-bit pair read port returns an aligned pair in one access.

The six highest registers also form three 16-bit address pointers. Pointer 0 is registers 26 and 27, pointer 1 is registers 28 and 29, and pointer 2 is registers 30 and 31; in each pair the lower-numbered register is the low byte. A pointer port selects one of them and returns an address in one of four forms: the plain pointer, the pointer plus an unsigned displacement, post-increment, or pre-decrement. The two auto-modify forms also write the changed pointer back at the clock edge.

A data-space port lets the registers answer memory-mapped loads and stores at addresses 0x00 to 0x1F. Any address from 0x20 upward misses the file. Instruction decode and the ALU sit outside this block.

Top module: `ptr_regfile`

## Requirements
- R1: While reset is active, and right after it is released, every register reads 0x00.
- R2: `rd_a_data` and `rd_b_data` show the indexed registers combinationally. A read of a register that is being written in the same cycle returns the value it held before the edge.
- R3: A byte write (`wr_en`=1, `wr_word`=0) replaces register `wr_idx` with `wr_data[7:0]` at the clock edge. No other register changes.
- R4: A word write (`wr_en`=1, `wr_word`=1) to an even `wr_idx` n stores `wr_data[7:0]` in register n and `wr_data[15:8]` in register n+1 at the same edge. A word write to an odd index changes no register.
- R5: `rd_pair_data` equals {register (`rd_a_idx` with bit 0 set), register (`rd_a_idx` with bit 0 clear)}. Bit 0 of `rd_a_idx` does not affect the pair read.
- R6: `ptr_sel` 0, 1 and 2 select the pointers {r27,r26}, {r29,r28} and {r31,r30}. `ptr_sel`=3 selects nothing: `ptr_addr` is 0 and no register changes.
- R7: `ptr_op`=00 gives the pointer unchanged on `ptr_addr`. `ptr_op`=11 gives the pointer plus `ptr_disp` (zero-extended, modulo 2^16). Neither form changes any register.
- R8: `ptr_op`=01 (post-increment) gives the old pointer on `ptr_addr` and writes back the old pointer plus one, wrapping 0xFFFF to 0x0000.
- R9: `ptr_op`=10 (pre-decrement) gives the old pointer minus one on `ptr_addr` and writes that same value back, wrapping 0x0000 to 0xFFFF.
- R10: For `dm_addr` below 0x20, `dm_hit` is 1, `dm_rdata` is register `dm_addr`, and `dm_we` writes `dm_wdata` into that register. For `dm_addr` of 0x20 or above, `dm_hit` is 0, `dm_rdata` is 0x00, and `dm_we` changes nothing.
- R11: When several sources write the same register in one cycle, the write port beats the data-space write, and the data-space write beats the pointer write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Index for read port A and for the pair read |
| rd_a_data | output | 8 | Register at `rd_a_idx` |
| rd_b_idx | input | 5 | Index for read port B |
| rd_b_data | output | 8 | Register at `rd_b_idx` |
| rd_pair_data | output | 16 | Aligned pair that contains `rd_a_idx` |
| wr_en | input | 1 | Write port enable |
| wr_word | input | 1 | 1 = 16-bit pair write, 0 = byte write |
| wr_idx | input | 5 | Write target (even index for word writes) |
| wr_data | input | 16 | Write data; only the low byte is used for byte writes |
| ptr_sel | input | 2 | Pointer select (0, 1, 2; 3 = none) |
| ptr_op | input | 2 | 00 plain, 01 post-increment, 10 pre-decrement, 11 displacement |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_addr | output | 16 | Effective address from the selected pointer |
| dm_addr | input | 16 | Data-space address |
| dm_we | input | 1 | Data-space write strobe |
| dm_wdata | input | 8 | Data-space write byte |
| dm_rdata | output | 8 | Data-space read byte (0 on a miss) |
| dm_hit | output | 1 | Address falls inside the register file |

## Verification
Assertions check every cycle that byte writes take effect, that word writes fill both halves of an even pair, that odd-index word writes leave the register untouched, and that a post-increment or pre-decrement with no competing write moves the pointer by exactly one. Several things are shown only by the bench scenarios:
- the combinational values on the read ports,
- the four address forms, including wrap-around at 0xFFFF and 0x0000,
- the data-space sweep across the register window and the I/O window above it,
- the three-way write priority on one register.

// File: rtl/rf_pkg.sv
package rf_pkg;

   // Pointer access forms on the pointer port
   typedef enum logic [1:0] {
      PTR_PLAIN   = 2'b00,
      PTR_POSTINC = 2'b01,
      PTR_PREDEC  = 2'b10,
      PTR_DISP    = 2'b11
   } ptr_op_e;

   // Number of 16-bit pointers carved from the top of the file
   localparam int unsigned PTR_COUNT = 3;

endpackage

// File: rtl/rf_ptr_unit.sv
module rf_ptr_unit
   import rf_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DISP_W  = 6,
   parameter bit DISP_EN = 1'b1
) (
   input  logic              en,
   input  logic [1:0]        op,
   input  logic [AW-1:0]     cur,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     addr,
   output logic              wb_en,
   output logic [AW-1:0]     wb_val
);

   logic [AW-1:0] inc_v;
   logic [AW-1:0] dec_v;
   logic [AW-1:0] off_v;

   assign inc_v = cur + AW'(1);
   assign dec_v = cur - AW'(1);

   generate
      if (DISP_EN) begin : g_disp
         assign off_v = cur + AW'(disp);
      end else begin : g_nodisp
         assign off_v = cur;
      end
   endgenerate

   always_comb begin
      addr   = '0;
      wb_en  = 1'b0;
      wb_val = cur;
      if (en) begin
         unique case (ptr_op_e'(op))
            PTR_POSTINC: begin
               addr   = cur;
               wb_en  = 1'b1;
               wb_val = inc_v;
            end
            PTR_PREDEC: begin
               addr   = dec_v;
               wb_en  = 1'b1;
               wb_val = dec_v;
            end
            PTR_DISP: addr = off_v;
            default:  addr = cur;
         endcase
      end
   end

endmodule

// File: rtl/rf_dmap.sv
module rf_dmap #(
   parameter int AW   = 16,
   parameter int NREG = 32,
   parameter int IW   = $clog2(NREG)
) (
   input  logic [AW-1:0] addr,
   output logic          hit,
   output logic [IW-1:0] idx
);

   localparam logic [AW-1:0] LIMIT = AW'(NREG);

   assign hit = (addr < LIMIT);
   assign idx = addr[IW-1:0];

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DW   = 8,
   parameter int NREG = 32,
   parameter int IW   = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_word,
   input  logic [IW-1:0]   wr_idx,
   input  logic [2*DW-1:0] wr_data,
   input  logic            dm_we,
   input  logic [IW-1:0]   dm_idx,
   input  logic [DW-1:0]   dm_wdata,
   input  logic            pw_en,
   input  logic [IW-1:0]   pw_idx,
   input  logic [2*DW-1:0] pw_val,
   output logic [DW-1:0]   q [NREG]
);

   logic [IW-1:0] wr_even;
   logic [IW-1:0] pw_even;
   logic          word_ok;

   assign wr_even = {wr_idx[IW-1:1], 1'b0};
   assign pw_even = {pw_idx[IW-1:1], 1'b0};
   assign word_ok = wr_en && wr_word && !wr_idx[0];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         localparam logic [IW-1:0] GI   = IW'(g);
         localparam bit            HIGH = (g % 2) == 1;
         localparam logic [IW-1:0] GE   = IW'(g - (g % 2));

         logic          hit_wr;
         logic          hit_dm;
         logic          hit_pw;
         logic [DW-1:0] wr_byte;
         logic [DW-1:0] pw_byte;
         logic [DW-1:0] r;

         if (HIGH) begin : g_hi
            assign wr_byte = wr_word ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
            assign pw_byte = pw_val[2*DW-1:DW];
         end else begin : g_lo
            assign wr_byte = wr_data[DW-1:0];
            assign pw_byte = pw_val[DW-1:0];
         end

         assign hit_wr = (wr_en && !wr_word && (wr_idx == GI)) ||
                         (word_ok && (wr_even == GE));
         assign hit_dm = dm_we && (dm_idx == GI);
         assign hit_pw = pw_en && (pw_even == GE);

         always_ff @(posedge clk) begin
            if (!rst_n)      r <= '0;
            else if (hit_wr) r <= wr_byte;
            else if (hit_dm) r <= dm_wdata;
            else if (hit_pw) r <= pw_byte;
         end

         assign q[g] = r;
      end
   endgenerate

   AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && !wr_word) |-> q[$past(wr_idx)] == $past(wr_data[DW-1:0])); // R3

   AST_WORD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(word_ok) |-> q[$past(wr_idx)] == $past(wr_data[DW-1:0])); // R4

   AST_WORD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(word_ok) |-> q[$past(wr_idx) + 1'b1] == $past(wr_data[2*DW-1:DW])); // R4

   AST_ODD_WORD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_word && wr_idx[0] && !dm_we && !pw_en)
      |-> q[$past(wr_idx)] == $past(q[wr_idx])); // R4

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
   import rf_pkg::*;
#(
   parameter int DW      = 8,
   parameter int NREG    = 32,
   parameter int AW      = 16,
   parameter int DISP_W  = 6,
   parameter bit DISP_EN = 1'b1,
   localparam int IW     = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     rd_a_idx,
   output logic [DW-1:0]     rd_a_data,
   input  logic [IW-1:0]     rd_b_idx,
   output logic [DW-1:0]     rd_b_data,
   output logic [2*DW-1:0]   rd_pair_data,
   input  logic              wr_en,
   input  logic              wr_word,
   input  logic [IW-1:0]     wr_idx,
   input  logic [2*DW-1:0]   wr_data,
   input  logic [1:0]        ptr_sel,
   input  logic [1:0]        ptr_op,
   input  logic [DISP_W-1:0] ptr_disp,
   output logic [AW-1:0]     ptr_addr,
   input  logic [AW-1:0]     dm_addr,
   input  logic              dm_we,
   input  logic [DW-1:0]     dm_wdata,
   output logic [DW-1:0]     dm_rdata,
   output logic              dm_hit
);

   localparam int            PBASE  = NREG - 2 * PTR_COUNT;
   localparam logic [IW-1:0] PBASE_I = IW'(PBASE);

   generate
      if (NREG != (1 << IW)) begin : g_chk_pow2
         $error("NREG must be a power of two");
      end
      if (NREG < 2 * PTR_COUNT + 2) begin : g_chk_size
         $error("NREG too small for the pointer pairs");
      end
      if (AW != 2 * DW) begin : g_chk_aw
         $error("pointer width must be two register widths");
      end
      if (DISP_W >= AW) begin : g_chk_disp
         $error("displacement must be narrower than the address");
      end
   endgenerate

   logic [DW-1:0]   q [NREG];
   logic            ptr_en;
   logic [IW-1:0]   ptr_lo;
   logic [IW-1:0]   ptr_hi;
   logic [AW-1:0]   ptr_cur;
   logic            pw_en;
   logic [AW-1:0]   pw_val;
   logic            map_hit;
   logic [IW-1:0]   map_idx;

   // read side
   assign rd_a_data    = q[rd_a_idx];
   assign rd_b_data    = q[rd_b_idx];
   assign rd_pair_data = {q[{rd_a_idx[IW-1:1], 1'b1}], q[{rd_a_idx[IW-1:1], 1'b0}]};

   // pointer selection
   assign ptr_en  = (ptr_sel < 2'(PTR_COUNT));
   assign ptr_lo  = PBASE_I + {IW'(ptr_sel), 1'b0};
   assign ptr_hi  = {ptr_lo[IW-1:1], 1'b1};
   assign ptr_cur = ptr_en ? {q[ptr_hi], q[ptr_lo]} : '0;

   rf_ptr_unit #(
      .AW      (AW),
      .DISP_W  (DISP_W),
      .DISP_EN (DISP_EN)
   ) ptr_i (
      .en     (ptr_en),
      .op     (ptr_op),
      .cur    (ptr_cur),
      .disp   (ptr_disp),
      .addr   (ptr_addr),
      .wb_en  (pw_en),
      .wb_val (pw_val)
   );

   rf_dmap #(
      .AW   (AW),
      .NREG (NREG),
      .IW   (IW)
   ) map_i (
      .addr (dm_addr),
      .hit  (map_hit),
      .idx  (map_idx)
   );

   assign dm_hit   = map_hit;
   assign dm_rdata = map_hit ? q[map_idx] : '0;

   rf_bank #(
      .DW   (DW),
      .NREG (NREG),
      .IW   (IW)
   ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_word  (wr_word),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .dm_we    (dm_we && map_hit),
      .dm_idx   (map_idx),
      .dm_wdata (dm_wdata),
      .pw_en    (pw_en),
      .pw_idx   (ptr_lo),
      .pw_val   (pw_val),
      .q        (q)
   );

   AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_sel == $past(ptr_sel)) &&
      $past(ptr_en && ptr_op == PTR_POSTINC && !wr_en && !dm_we)
      |-> ptr_cur == $past(ptr_cur) + AW'(1)); // R8

   AST_PREDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_sel == $past(ptr_sel)) &&
      $past(ptr_en && ptr_op == PTR_PREDEC && !wr_en && !dm_we)
      |-> ptr_cur == $past(ptr_addr)); // R9

   AST_NO_PTR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_sel == 2'd3) |-> ptr_addr == '0); // R6

endmodule

// File: tb/ptr_regfile_tb_top.sv
module ptr_regfile_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx = '0;
   logic [4:0]  rd_b_idx = '0;
   logic [7:0]  rd_a_data, rd_b_data;
   logic [15:0] rd_pair_data;
   logic        wr_en = 1'b0;
   logic        wr_word = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  ptr_sel = 2'd3;
   logic [1:0]  ptr_op = 2'd0;
   logic [5:0]  ptr_disp = '0;
   logic [15:0] ptr_addr;
   logic [15:0] dm_addr = 16'h0100;
   logic        dm_we = 1'b0;
   logic [7:0]  dm_wdata = '0;
   logic [7:0]  dm_rdata;
   logic        dm_hit;

   always #4 clk = ~clk;

   ptr_regfile dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .rd_pair_data(rd_pair_data),
      .wr_en(wr_en), .wr_word(wr_word), .wr_idx(wr_idx), .wr_data(wr_data),
      .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_disp(ptr_disp), .ptr_addr(ptr_addr),
      .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
      .dm_rdata(dm_rdata), .dm_hit(dm_hit)
   );

   logic [7:0] model [32];
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ptr_of(int sel);
      return {model[26 + 2*sel + 1], model[26 + 2*sel]};
   endfunction

   function automatic logic [15:0] exp_addr(int sel, int op, logic [5:0] d);
      logic [15:0] p;
      if (sel == 3) return 16'h0000;
      p = ptr_of(sel);
      case (op)
         1: return p;
         2: return p - 16'd1;
         3: return p + {10'd0, d};
         default: return p;
      endcase
   endfunction

   // Clock one edge, updating the model by the priority rules (R11)
   task automatic tick();
      logic [7:0] nx [32];
      logic [15:0] v;
      int b;
      for (int i = 0; i < 32; i++) nx[i] = model[i];
      if (ptr_sel != 2'd3 && (ptr_op == 2'd1 || ptr_op == 2'd2)) begin
         b = 26 + 2*int'(ptr_sel);
         v = (ptr_op == 2'd1) ? ptr_of(int'(ptr_sel)) + 16'd1 : ptr_of(int'(ptr_sel)) - 16'd1;
         nx[b] = v[7:0];
         nx[b+1] = v[15:8];
      end
      if (dm_we && dm_addr < 16'h0020) nx[dm_addr[4:0]] = dm_wdata;
      if (wr_en) begin
         if (!wr_word) nx[wr_idx] = wr_data[7:0];
         else if (!wr_idx[0]) begin
            nx[wr_idx] = wr_data[7:0];
            nx[wr_idx + 5'd1] = wr_data[15:8];
         end
      end
      @(posedge clk);
      #1;
      for (int i = 0; i < 32; i++) model[i] = nx[i];
      wr_en = 1'b0; wr_word = 1'b0; dm_we = 1'b0; ptr_op = 2'd0; ptr_sel = 2'd3;
   endtask

   task automatic verify_all(string req);
      for (int i = 0; i < 32; i++) begin
         rd_a_idx = 5'(i);
         rd_b_idx = 5'(31 - i);
         #1;
         check(req, $sformatf("reg %0d port A", i), {24'd0, rd_a_data}, {24'd0, model[i]});
         check(req, $sformatf("reg %0d port B", 31 - i), {24'd0, rd_b_data}, {24'd0, model[31 - i]});
      end
   endtask

   task automatic word_write(int idx, logic [15:0] d);
      wr_en = 1'b1; wr_word = 1'b1; wr_idx = 5'(idx); wr_data = d;
      tick();
   endtask

   initial begin
      string tg;
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      rd_a_idx = 5'd9;
      check("R1", "value during reset", {24'd0, rd_a_data}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      verify_all("R1");

      // R2/R3: byte write to every register, old value visible before the edge
      for (int i = 0; i < 32; i++) begin
         wr_en = 1'b1; wr_word = 1'b0; wr_idx = 5'(i);
         wr_data = {8'hEE, 8'((i * 37 + 11) & 8'hFF)};
         rd_a_idx = 5'(i);
         #1;
         check("R2", $sformatf("old value reg %0d", i), {24'd0, rd_a_data}, {24'd0, model[i]});
         tick();
         rd_a_idx = 5'(i);
         #1;
         check("R3", $sformatf("new value reg %0d", i), {24'd0, rd_a_data},
               {24'd0, 8'((i * 37 + 11) & 8'hFF)});
      end
      verify_all("R3");

      // R4/R5: word write into every even pair, pair read with either index
      for (int p = 0; p < 32; p += 2) begin
         word_write(p, 16'((p * 1009 + 16'h0A07) & 16'hFFFF));
         rd_a_idx = 5'(p + 1);
         #1;
         check("R5", $sformatf("pair %0d via odd index", p), {16'd0, rd_pair_data},
               {16'd0, 16'((p * 1009 + 16'h0A07) & 16'hFFFF)});
         rd_a_idx = 5'(p);
         #1;
         check("R5", $sformatf("pair %0d via even index", p), {16'd0, rd_pair_data},
               {16'd0, 16'((p * 1009 + 16'h0A07) & 16'hFFFF)});
      end
      // odd-index word write must change nothing
      word_write(7, 16'h5AA5);
      verify_all("R4");

      // R6..R9: all pointer selects against all forms
      word_write(26, 16'h1234);
      word_write(28, 16'hFFFF);
      word_write(30, 16'h0000);
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < 4; o++) begin
            tg = (s == 3) ? "R6" : (o == 1) ? "R8" : (o == 2) ? "R9" : "R7";
            ptr_sel = 2'(s); ptr_op = 2'(o); ptr_disp = 6'(6'h2A + s * 7);
            #1;
            check(tg, $sformatf("address sel %0d op %0d", s, o), {16'd0, ptr_addr},
                  {16'd0, exp_addr(s, o, 6'(6'h2A + s * 7))});
            tick();
            verify_all(tg);
         end
      end
      // wrap cases with literal expectations
      word_write(28, 16'hFFFF);
      ptr_sel = 2'd1; ptr_op = 2'd1;
      tick();
      rd_a_idx = 5'd28;
      #1;
      check("R8", "post-increment wrap", {16'd0, rd_pair_data}, 32'h0000);
      word_write(30, 16'h0000);
      ptr_sel = 2'd2; ptr_op = 2'd2;
      #1;
      check("R9", "pre-decrement wrap address", {16'd0, ptr_addr}, 32'hFFFF);
      tick();
      rd_a_idx = 5'd30;
      #1;
      check("R9", "pre-decrement wrap value", {16'd0, rd_pair_data}, 32'hFFFF);

      // R10: data-space read sweep over register and I/O windows
      for (int a = 0; a < 16'h60; a++) begin
         dm_addr = 16'(a);
         #1;
         check("R10", $sformatf("hit at %h", a), {31'd0, dm_hit}, (a < 32) ? 32'd1 : 32'd0);
         check("R10", $sformatf("rdata at %h", a), {24'd0, dm_rdata},
               (a < 32) ? {24'd0, model[a]} : 32'd0);
      end
      begin
         int wa[6] = '{3, 31, 32, 63, 95, 16'h1F03};
         for (int k = 0; k < 6; k++) begin
            dm_addr = 16'(wa[k]); dm_we = 1'b1; dm_wdata = 8'(8'hC1 + k);
            tick();
         end
      end
      verify_all("R10");
      dm_addr = 16'h0100;

      // R11: write priority on one register
      word_write(26, 16'h10FF);
      ptr_sel = 2'd0; ptr_op = 2'd1;
      wr_en = 1'b1; wr_word = 1'b0; wr_idx = 5'd26; wr_data = 16'h0055;
      tick();
      rd_a_idx = 5'd26;
      #1;
      check("R11", "write port over pointer", {16'd0, rd_pair_data}, 32'h1155);
      ptr_sel = 2'd0; ptr_op = 2'd2;
      dm_addr = 16'h001B; dm_we = 1'b1; dm_wdata = 8'hAA;
      tick();
      rd_a_idx = 5'd26;
      #1;
      check("R11", "data space over pointer", {16'd0, rd_pair_data}, 32'hAA54);
      wr_en = 1'b1; wr_word = 1'b0; wr_idx = 5'd5; wr_data = 16'h0011;
      dm_addr = 16'h0005; dm_we = 1'b1; dm_wdata = 8'h22;
      tick();
      rd_a_idx = 5'd5;
      #1;
      check("R11", "write port over data space", {24'd0, rd_a_data}, 32'h11);
      verify_all("R11");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule